// File: doc/BRIEF.md
# Cartridge Address Mapper and Decoder

This block sits between a 24-bit processor bus and the devices of a cartridge-slot console. It splits each address into an 8-bit bank and a 16-bit in-bank offset. From those it drives one active-low select for work RAM, the console register window, cartridge ROM or cartridge save RAM. It also produces the linear byte offsets that the ROM and save-RAM arrays need. Two cartridge wiring layouts are supported. The narrow layout places 32 KB of ROM in the upper half of every bank. The wide layout gives a full 64 KB bank to ROM in the upper bank ranges. Save-RAM sits in a different window in each layout.

The upper half of the bank space (banks $80–$FF) mirrors the lower half. The exception is banks $7E–$7F, which always belong to work RAM; their mirrors $FE–$FF remain cartridge space. A one-bit speed register sets whether accesses through the upper mirror count as fast cycles. It is written by a bus write to a fixed register offset. The register is a two-state machine: `SPD_SLOW` (the reset state) and `SPD_FAST`. A write carrying data bit 1 moves it to `SPD_FAST`. A write carrying data bit 0 moves it to `SPD_SLOW`. With no write it stays where it is.

Top module: `cart_map_top`

## Requirements
- R1: In system banks (bank & $7F below $40), offsets $0000–$1FFF select work RAM, $2000–$7FFF select the register window, and $8000–$FFFF select ROM. The only exception is the save-RAM window of R7.
- R2: At most one of the four selects is active in any cycle.
- R3: In the narrow layout (map_wide=0), ROM answers only at offsets $8000–$FFFF. rom_off = (bank&$7F)×$8000 + (offset−$8000), so $03:8000 gives $018000. A low-half offset in banks $40–$6F selects nothing.
- R4: In the wide layout (map_wide=1), every offset of banks $40–$7D and $C0–$FF selects ROM, as does the upper half of system banks. rom_off = (bank mod $40)×$10000 + offset.
- R5: Banks $7E and $7F select work RAM at every offset in both layouts. Banks $FE and $FF select ROM wherever the layout maps ROM.
- R6: Banks $80–$FF decode exactly as banks $00–$7D: the same select and the same offsets.
- R7: Save RAM is selected as follows. In the narrow layout it is banks $70–$7D at $0000–$7FFF, with sram_off = offset & $7FFF. In the wide layout it is banks $20–$3F at $6000–$7FFF, mirrored at $A0–$BF, with sram_off = (bank mod 4)×$2000 + (offset & $1FFF).
- R8: The speed state is `SPD_SLOW` after reset. A bus write (wr_n=0) to offset $2A0D in a system bank loads data bit wdata0 at the clock edge; a write to that offset in any other bank has no effect. fast_cyc = 1 exactly when bank bit 7 is set and the state is `SPD_FAST`.
- R9: Selects are active-low. All four are high whenever rd_n and wr_n are both high.
- R10: rom_off is masked to 1 KB << rom_size; codes of 12 or more leave all 22 bits.
- R11: sram_off is masked to 1 KB << sram_size, with the code clamped to the range 1–5 (2 KB to 32 KB).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the speed register |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 24 | Bus address, bank in bits 23:16 |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| wdata0 | input | 1 | Bus data bit 0, loaded into the speed register |
| map_wide | input | 1 | 0 = 32 KB-per-bank layout, 1 = 64 KB-per-bank layout |
| rom_size | input | 4 | ROM size code, bytes = 1 KB << code |
| sram_size | input | 3 | Save-RAM size code, bytes = 1 KB << code |
| wram_sel_n | output | 1 | Work RAM select |
| reg_sel_n | output | 1 | Register window select |
| rom_sel_n | output | 1 | Cartridge ROM select |
| sram_sel_n | output | 1 | Save-RAM select |
| rom_off | output | 22 | Linear ROM byte offset |
| sram_off | output | 15 | Linear save-RAM byte offset |
| fast_cyc | output | 1 | 1 = fast cycle, 0 = slow cycle |

## Verification
The decode is combinational. A wrong select or offset therefore shows at the ports in the same cycle the address is presented, and the bench samples it there. The speed register is the only stored state. If it holds a wrong value, fast_cyc is wrong on the first upper-mirror access after the faulty write, one clock edge later. A write to the register offset outside the system banks must leave fast_cyc unchanged on the next upper-mirror read.

// File: rtl/cart_map_pkg.sv
package cart_map_pkg;
    typedef enum logic {
        MAP_NARROW = 1'b0,
        MAP_WIDE   = 1'b1
    } map_mode_e;

    typedef enum logic {
        SPD_SLOW = 1'b0,
        SPD_FAST = 1'b1
    } spd_state_e;

    typedef struct packed {
        logic wram;
        logic regs;
        logic rom;
        logic sram;
    } sel_t;
endpackage

// File: rtl/cart_speed_fsm.sv
module cart_speed_fsm
    import cart_map_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic wbit,
    output logic fast_en
);
    spd_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SPD_SLOW;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SPD_SLOW: if (load && wbit)  state_d = SPD_FAST;
            SPD_FAST: if (load && !wbit) state_d = SPD_SLOW;
            default:  state_d = SPD_SLOW;
        endcase
    end

    // outputs
    always_comb begin
        fast_en = 1'b0;
        unique case (state_q)
            SPD_SLOW: fast_en = 1'b0;
            SPD_FAST: fast_en = 1'b1;
            default:  fast_en = 1'b0;
        endcase
    end

    AST_SPD_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (fast_en == $past(wbit))); // R8
    AST_SPD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(fast_en)); // R8
endmodule

// File: rtl/cart_region_dec.sv
module cart_region_dec
    import cart_map_pkg::*;
#(
    parameter int BANK_W = 8,
    parameter int OFF_W  = 16
) (
    input  logic [BANK_W-1:0] bank,
    input  logic [OFF_W-1:0]  off,
    input  map_mode_e         mode,
    input  logic              active,
    output sel_t              sel
);
    localparam int LB_W = BANK_W - 1;

    logic [LB_W-1:0] lb;
    logic            hi_img, sys_bank, wram_bank, upper;
    logic            sram_hit, rom_hit;

    assign lb       = bank[LB_W-1:0];
    assign hi_img   = bank[BANK_W-1];
    assign sys_bank = (lb < LB_W'(8'h40));
    assign wram_bank = (lb >= LB_W'(8'h7E)) && !hi_img;
    assign upper    = off[OFF_W-1];

    always_comb begin
        sram_hit = 1'b0;
        rom_hit  = 1'b0;
        unique case (mode)
            MAP_NARROW: begin
                sram_hit = (lb >= LB_W'(8'h70)) && (lb <= LB_W'(8'h7D)) && !upper;
                rom_hit  = upper && !wram_bank;
            end
            MAP_WIDE: begin
                sram_hit = (lb >= LB_W'(8'h20)) && (lb < LB_W'(8'h40)) &&
                           (off[OFF_W-1:OFF_W-3] == 3'b011);
                rom_hit  = (upper || !sys_bank) && !wram_bank;
            end
            default: ;
        endcase
    end

    always_comb begin
        sel = '0;
        if (active) begin
            if (wram_bank)                              sel.wram = 1'b1;
            else if (sram_hit)                          sel.sram = 1'b1;
            else if (rom_hit)                           sel.rom  = 1'b1;
            else if (sys_bank && off < OFF_W'(16'h2000)) sel.wram = 1'b1;
            else if (sys_bank)                          sel.regs = 1'b1;
        end
    end
endmodule

// File: rtl/cart_offset_gen.sv
module cart_offset_gen
    import cart_map_pkg::*;
#(
    parameter int LB_W    = 7,
    parameter int OFF_W   = 16,
    parameter int RCODE_W = 4,
    parameter int SCODE_W = 3,
    parameter int SRAM_AW = 15
) (
    input  logic [LB_W-1:0]    lb,
    input  logic [OFF_W-1:0]   off,
    input  map_mode_e          mode,
    input  logic [RCODE_W-1:0] rom_code,
    input  logic [SCODE_W-1:0] sram_code,
    output logic [LB_W+OFF_W-2:0] rom_off,
    output logic [SRAM_AW-1:0] sram_off
);
    localparam int ROM_AW   = LB_W + OFF_W - 1;
    localparam int UNIT_LOG = 10;
    localparam int SC_MIN   = 1;
    localparam int SC_MAX   = SRAM_AW - UNIT_LOG;

    logic [ROM_AW-1:0]  rom_raw, rom_mask;
    logic [SRAM_AW-1:0] sram_raw, sram_mask;
    int                 sc;

    always_comb begin
        unique case (mode)
            MAP_NARROW: begin
                rom_raw  = {lb, off[OFF_W-2:0]};
                sram_raw = off[SRAM_AW-1:0];
            end
            MAP_WIDE: begin
                rom_raw  = {lb[LB_W-2:0], off};
                sram_raw = {lb[1:0], off[SRAM_AW-3:0]};
            end
            default: begin
                rom_raw  = '0;
                sram_raw = '0;
            end
        endcase
    end

    always_comb begin
        if (32'(rom_code) >= ROM_AW - UNIT_LOG) rom_mask = '1;
        else rom_mask = (ROM_AW'(1) << (32'(rom_code) + UNIT_LOG)) - ROM_AW'(1);
    end

    always_comb begin
        sc = 32'(sram_code);
        if (sc < SC_MIN) sc = SC_MIN;
        if (sc > SC_MAX) sc = SC_MAX;
        sram_mask = (SRAM_AW'(1) << (sc + UNIT_LOG)) - SRAM_AW'(1);
    end

    assign rom_off  = rom_raw & rom_mask;
    assign sram_off = sram_raw & sram_mask;
endmodule

// File: rtl/cart_map_top.sv
module cart_map_top
    import cart_map_pkg::*;
#(
    parameter int          BANK_W  = 8,
    parameter int          OFF_W   = 16,
    parameter int          RCODE_W = 4,
    parameter int          SCODE_W = 3,
    parameter int          SRAM_AW = 15,
    parameter logic [15:0] SPD_REG_OFF = 16'h2A0D
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [BANK_W+OFF_W-1:0]       addr,
    input  logic                          rd_n,
    input  logic                          wr_n,
    input  logic                          wdata0,
    input  logic                          map_wide,
    input  logic [RCODE_W-1:0]            rom_size,
    input  logic [SCODE_W-1:0]            sram_size,
    output logic                          wram_sel_n,
    output logic                          reg_sel_n,
    output logic                          rom_sel_n,
    output logic                          sram_sel_n,
    output logic [BANK_W+OFF_W-3:0]       rom_off,
    output logic [SRAM_AW-1:0]            sram_off,
    output logic                          fast_cyc
);
    localparam int LB_W = BANK_W - 1;

    logic [BANK_W-1:0] bank;
    logic [OFF_W-1:0]  off;
    map_mode_e         mode;
    sel_t              sel;
    logic              active, spd_load, fast_en;

    assign bank   = addr[BANK_W+OFF_W-1:OFF_W];
    assign off    = addr[OFF_W-1:0];
    assign mode   = map_wide ? MAP_WIDE : MAP_NARROW;
    assign active = !rd_n || !wr_n;
    assign spd_load = !wr_n && (bank[LB_W-1:0] < LB_W'(8'h40)) &&
                      (off == OFF_W'(SPD_REG_OFF));

    cart_region_dec #(.BANK_W(BANK_W), .OFF_W(OFF_W)) u_dec (
        .bank(bank), .off(off), .mode(mode), .active(active), .sel(sel)
    );

    cart_offset_gen #(.LB_W(LB_W), .OFF_W(OFF_W), .RCODE_W(RCODE_W),
                      .SCODE_W(SCODE_W), .SRAM_AW(SRAM_AW)) u_off (
        .lb(bank[LB_W-1:0]), .off(off), .mode(mode), .rom_code(rom_size),
        .sram_code(sram_size), .rom_off(rom_off), .sram_off(sram_off)
    );

    cart_speed_fsm u_spd (
        .clk(clk), .rst_n(rst_n), .load(spd_load), .wbit(wdata0), .fast_en(fast_en)
    );

    assign wram_sel_n = ~sel.wram;
    assign reg_sel_n  = ~sel.regs;
    assign rom_sel_n  = ~sel.rom;
    assign sram_sel_n = ~sel.sram;
    assign fast_cyc   = bank[BANK_W-1] & fast_en;

    AST_ONE_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({wram_sel_n, reg_sel_n, rom_sel_n, sram_sel_n}) >= 3); // R2
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_n && wr_n) |-> (wram_sel_n && reg_sel_n && rom_sel_n && sram_sel_n)); // R9
    AST_WRAM_RSV: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_n && addr[23:17] == 7'b0111111) |-> !wram_sel_n); // R5
    AST_FAST_HI: assert property (@(posedge clk) disable iff (!rst_n)
        fast_cyc |-> addr[23]); // R8
    AST_ROM_LO_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
        (!map_wide && !rom_sel_n) |-> addr[15]); // R3
endmodule

// File: tb/cart_map_top_tb_top.sv
module cart_map_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] addr = '0;
    logic        rd_n = 1'b1, wr_n = 1'b1, wdata0 = 1'b0, map_wide = 1'b0;
    logic [3:0]  rom_size = 4'd12;
    logic [2:0]  sram_size = 3'd5;
    logic        wram_sel_n, reg_sel_n, rom_sel_n, sram_sel_n, fast_cyc;
    logic [21:0] rom_off;
    logic [14:0] sram_off;

    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    cart_map_top dut_i (
        .clk(clk), .rst_n(rst_n), .addr(addr), .rd_n(rd_n), .wr_n(wr_n),
        .wdata0(wdata0), .map_wide(map_wide), .rom_size(rom_size),
        .sram_size(sram_size), .wram_sel_n(wram_sel_n), .reg_sel_n(reg_sel_n),
        .rom_sel_n(rom_sel_n), .sram_sel_n(sram_sel_n), .rom_off(rom_off),
        .sram_off(sram_off), .fast_cyc(fast_cyc)
    );

    // {wide, addr, rom code, sram code, exp sel {wram,reg,rom,sram}, exp offset}
    localparam int NV = 24;
    localparam logic [59:0] VEC [NV] = '{
        {1'b0, 24'h000100, 4'd12, 3'd5, 4'b1000, 24'h000000}, // R1 wram
        {1'b0, 24'h002100, 4'd12, 3'd5, 4'b0100, 24'h000000}, // R1 regs
        {1'b0, 24'h038000, 4'd12, 3'd5, 4'b0010, 24'h018000}, // R3
        {1'b0, 24'h7E1234, 4'd12, 3'd5, 4'b1000, 24'h000000}, // R5
        {1'b0, 24'h7F9000, 4'd12, 3'd5, 4'b1000, 24'h000000}, // R5
        {1'b0, 24'hFE8000, 4'd12, 3'd5, 4'b0010, 24'h3F0000}, // R5
        {1'b0, 24'h838000, 4'd12, 3'd5, 4'b0010, 24'h018000}, // R6
        {1'b0, 24'h700010, 4'd12, 3'd5, 4'b0001, 24'h000010}, // R7
        {1'b0, 24'hF17FFF, 4'd12, 3'd5, 4'b0001, 24'h007FFF}, // R7 R6
        {1'b0, 24'h451000, 4'd12, 3'd5, 4'b0000, 24'h000000}, // R3 unmapped
        {1'b1, 24'h400000, 4'd12, 3'd5, 4'b0010, 24'h000000}, // R4
        {1'b1, 24'hC12345, 4'd12, 3'd5, 4'b0010, 24'h012345}, // R4
        {1'b1, 24'h7DFFFF, 4'd12, 3'd5, 4'b0010, 24'h3DFFFF}, // R4
        {1'b1, 24'hFF0000, 4'd12, 3'd5, 4'b0010, 24'h3F0000}, // R5
        {1'b1, 24'h206000, 4'd12, 3'd5, 4'b0001, 24'h000000}, // R7
        {1'b1, 24'hA37001, 4'd12, 3'd5, 4'b0001, 24'h007001}, // R7
        {1'b1, 24'h059000, 4'd12, 3'd5, 4'b0010, 24'h059000}, // R4
        {1'b1, 24'h106000, 4'd12, 3'd5, 4'b0100, 24'h000000}, // R1
        {1'b1, 24'h7E0000, 4'd12, 3'd5, 4'b1000, 24'h000000}, // R5
        {1'b0, 24'h039234, 4'd4,  3'd5, 4'b0010, 24'h001234}, // R10
        {1'b1, 24'h059000, 4'd15, 3'd5, 4'b0010, 24'h059000}, // R10
        {1'b0, 24'h701234, 4'd12, 3'd1, 4'b0001, 24'h000234}, // R11
        {1'b0, 24'h701234, 4'd12, 3'd0, 4'b0001, 24'h000234}, // R11
        {1'b0, 24'h701234, 4'd12, 3'd7, 4'b0001, 24'h001234}  // R11
    };

    task automatic check(input string req, input logic [23:0] act, input logic [23:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus(input logic [23:0] a, input logic r, input logic w, input logic d);
        @(negedge clk);
        addr = a; rd_n = ~r; wr_n = ~w; wdata0 = d;
        #2;
    endtask

    initial begin
        #150000;
        bad++; total++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // reset state: slow, idle selects (R8, R9)
        bus(24'h808000, 1'b0, 1'b0, 1'b0);
        check("R9 idle", {20'h0, wram_sel_n, reg_sel_n, rom_sel_n, sram_sel_n}, 24'hF);
        bus(24'h808000, 1'b1, 1'b0, 1'b0);
        check("R8 reset slow", {23'h0, fast_cyc}, 24'h0);

        for (int i = 0; i < NV; i++) begin
            logic [59:0] v;
            v = VEC[i];
            map_wide = v[59]; rom_size = v[34:31]; sram_size = v[30:28];
            bus(v[58:35], 1'b1, 1'b0, 1'b0);
            check($sformatf("R1-vec%0d sel", i),
                  {20'h0, ~{wram_sel_n, reg_sel_n, rom_sel_n, sram_sel_n}}, {20'h0, v[27:24]});
            if (v[25]) check($sformatf("R3/R4 vec%0d rom_off", i), {2'b0, rom_off}, v[23:0]);
            if (v[24]) check($sformatf("R7 vec%0d sram_off", i), {9'b0, sram_off}, v[23:0]);
        end
        map_wide = 1'b0; rom_size = 4'd12; sram_size = 3'd5;

        // R2: write strobe also decodes, single select
        bus(24'h038000, 1'b0, 1'b1, 1'b0);
        check("R2 write sel", {20'h0, ~{wram_sel_n, reg_sel_n, rom_sel_n, sram_sel_n}}, 24'h2);

        // R8: set speed through system bank register write
        bus(24'h002A0D, 1'b0, 1'b1, 1'b1);
        bus(24'h808000, 1'b1, 1'b0, 1'b0);
        check("R8 fast high mirror", {23'h0, fast_cyc}, 24'h1);
        bus(24'h008000, 1'b1, 1'b0, 1'b0);
        check("R8 low bank slow", {23'h0, fast_cyc}, 24'h0);
        // R8: write outside system banks ignored
        bus(24'h452A0D, 1'b0, 1'b1, 1'b0);
        bus(24'hC00000, 1'b1, 1'b0, 1'b0);
        check("R8 ignored write", {23'h0, fast_cyc}, 24'h1);
        // R8: clear via upper mirror of system bank
        bus(24'h802A0D, 1'b0, 1'b1, 1'b0);
        bus(24'h808000, 1'b1, 1'b0, 1'b0);
        check("R8 cleared", {23'h0, fast_cyc}, 24'h0);

        // R9 final idle
        bus(24'h000100, 1'b0, 1'b0, 1'b0);
        check("R9 idle end", {20'h0, wram_sel_n, reg_sel_n, rom_sel_n, sram_sel_n}, 24'hF);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule